// File: doc/BRIEF.md
# Status-Flag ALU

This block is an 8-bit arithmetic logic unit with a registered output stage. It takes two operands and a 4-bit operation code. The code picks one of sixteen functions: add, subtract, step up, step down, two's-complement negation, four bitwise forms, two pass-throughs, four single-bit shifts and a compare. The chosen result is captured on the next rising clock edge. Six status flags are captured with it: carry, parity, overflow, positive, zero and negative.

A surrounding datapath applies operands and a code in one cycle and reads the result and flags after the next clock edge. The compare function leaves operand A on the result port. Its flags describe the difference A − B, so a controller can test equality, sign and unsigned order without overwriting a stored value. The operand width is a parameter. The operation map and the flag rules assume the 8-bit default.

Top module: `flag_alu`

## Requirements
- R1: Outputs are registered. The result and flags at the ports reflect the operands and code present before the most recent rising edge. A rising edge with `rst` high clears the result and all six flags to 0.
- R2: Code 0000 adds. The result is (A + B) mod 256. Carry is the unsigned carry out. Overflow is set when the signed sum lies outside −128..127.
- R3: Code 0001 subtracts. The result is (A − B) mod 256. Carry is the borrow and is set when A < B unsigned. Overflow is set when the signed difference lies outside −128..127.
- R4: Code 0010 gives A + 1 and code 0011 gives A − 1. For the increment, carry is set only for A = 0xFF and overflow only for A = 0x7F. For the decrement, carry (borrow) is set only for A = 0x00 and overflow only for A = 0x80.
- R5: Code 1101 gives 0 − A. Carry is set when A is non-zero. Overflow is set only for A = 0x80, which returns 0x80.
- R6: Each of these codes clears carry and overflow: 0100 (A AND B), 0101 (A OR B), 0111 (A XOR B), 1000 (NOT A), 0110 (A passed through) and 1111 (B passed through).
- R7: Codes 1001, 1010 and 1011 shift A by one bit and clear overflow. 1001 shifts left and fills with 0. 1010 shifts right and fills with 0. 1011 shifts right and keeps bit 7. Carry receives the bit shifted out: bit 7 for 1001 and bit 0 for 1010 and 1011.
- R8: Code 1100 shifts A left by one and fills with 0. Carry receives old bit 7. Overflow is set when bits 7 and 6 of A differ, which means the sign changed.
- R9: Code 1110 compares. The result port shows A unchanged. Carry, overflow, parity, zero, negative and positive are the values subtraction (R3) would give for A − B.
- R10: Parity is the XOR of the eight bits of the flag basis. The basis is the difference for compare and the result for every other code. Parity is set for an odd count of ones.
- R11: Zero is set when the basis is all zeros. Negative equals basis bit 7. Positive is set when bit 7 is clear and the basis is non-zero. At most one of the three is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| opa_i | input | W | Operand A |
| opb_i | input | W | Operand B |
| opc_i | input | 4 | Operation code |
| res_o | output | W | Registered result |
| cry_o | output | 1 | Carry, borrow or shifted-out bit |
| par_o | output | 1 | Odd parity of the flag basis |
| ovf_o | output | 1 | Signed overflow |
| pos_o | output | 1 | Basis strictly positive |
| zro_o | output | 1 | Basis is zero |
| neg_o | output | 1 | Basis bit 7 set |

## Verification
The bench builds the block with the default W = 8. At that width every one-operand function can be swept across all 256 values of A. This reaches each carry and overflow corner at 0x00, 0x7F, 0x80 and 0xFF without picking them by hand. Two-operand functions are covered by hand-picked corner pairs plus a pseudo-random stream across all sixteen codes. Every output bit is compared against an integer-arithmetic model derived from the requirements.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD   = 4'b0000,
    OP_SUB   = 4'b0001,
    OP_INC   = 4'b0010,
    OP_DEC   = 4'b0011,
    OP_AND   = 4'b0100,
    OP_OR    = 4'b0101,
    OP_PASSA = 4'b0110,
    OP_XOR   = 4'b0111,
    OP_NOTA  = 4'b1000,
    OP_LSL   = 4'b1001,
    OP_LSR   = 4'b1010,
    OP_ASR   = 4'b1011,
    OP_ASL   = 4'b1100,
    OP_NEG   = 4'b1101,
    OP_CMP   = 4'b1110,
    OP_PASSB = 4'b1111
  } alu_op_e;

  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_SHIFT = 2'd2
  } alu_cls_e;

  typedef struct packed {
    logic cry;
    logic par;
    logic ovf;
    logic pos;
    logic zro;
    logic neg;
  } alu_flags_t;

  function automatic alu_cls_e op_class(alu_op_e op);
    case (op)
      OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_NEG, OP_CMP: return CLS_ARITH;
      OP_LSL, OP_LSR, OP_ASR, OP_ASL:                 return CLS_SHIFT;
      default:                                        return CLS_LOGIC;
    endcase
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] sum_o,
  output logic         cry_o,
  output logic         ovf_o
);

  localparam int MSB = W - 1;

  logic [W-1:0] x_in;
  logic [W-1:0] y_in;
  logic         c_in;
  logic         borrow_mode;
  logic [W:0]   total;

  // One adder serves every arithmetic code; operands are steered into it.
  always_comb begin
    x_in        = a_i;
    y_in        = b_i;
    c_in        = 1'b0;
    borrow_mode = 1'b0;
    case (op_i)
      OP_ADD: begin
        x_in = a_i; y_in = b_i; c_in = 1'b0;
      end
      OP_SUB, OP_CMP: begin
        x_in = a_i; y_in = ~b_i; c_in = 1'b1; borrow_mode = 1'b1;
      end
      OP_INC: begin
        x_in = a_i; y_in = '0; c_in = 1'b1;
      end
      OP_DEC: begin
        x_in = a_i; y_in = '1; c_in = 1'b0; borrow_mode = 1'b1;
      end
      OP_NEG: begin
        x_in = '0; y_in = ~a_i; c_in = 1'b1; borrow_mode = 1'b1;
      end
      default: begin
        x_in = a_i; y_in = b_i; c_in = 1'b0;
      end
    endcase
  end

  assign total = {1'b0, x_in} + {1'b0, y_in} + {{W{1'b0}}, c_in};
  assign sum_o = total[W-1:0];

  // Subtractive forms report a borrow, the inverse of the adder carry.
  assign cry_o = borrow_mode ? ~total[W] : total[W];

  // Signed overflow: like-signed adder inputs giving an unlike-signed sum.
  assign ovf_o = (x_in[MSB] == y_in[MSB]) && (total[MSB] != x_in[MSB]);

endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o
);

  always_comb begin
    case (op_i)
      OP_AND:   res_o = a_i & b_i;
      OP_OR:    res_o = a_i | b_i;
      OP_XOR:   res_o = a_i ^ b_i;
      OP_NOTA:  res_o = ~a_i;
      OP_PASSB: res_o = b_i;
      default:  res_o = a_i;
    endcase
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  alu_op_e      op_i,
  output logic [W-1:0] res_o,
  output logic         cry_o,
  output logic         ovf_o
);

  localparam int MSB = W - 1;

  logic [W-1:0] left_v;
  logic [W-1:0] rlog_v;
  logic [W-1:0] rari_v;

  assign left_v = {a_i[W-2:0], 1'b0};
  assign rlog_v = {1'b0, a_i[W-1:1]};
  assign rari_v = {a_i[MSB], a_i[W-1:1]};

  always_comb begin
    res_o = left_v;
    cry_o = a_i[MSB];
    ovf_o = 1'b0;
    case (op_i)
      OP_LSL: begin
        res_o = left_v; cry_o = a_i[MSB];
      end
      OP_LSR: begin
        res_o = rlog_v; cry_o = a_i[0];
      end
      OP_ASR: begin
        res_o = rari_v; cry_o = a_i[0];
      end
      OP_ASL: begin
        res_o = left_v; cry_o = a_i[MSB];
        ovf_o = a_i[MSB] ^ a_i[MSB-1];
      end
      default: begin
        res_o = left_v; cry_o = a_i[MSB];
      end
    endcase
  end

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [3:0]   opc_i,
  output logic [W-1:0] res_o,
  output logic         cry_o,
  output logic         par_o,
  output logic         ovf_o,
  output logic         pos_o,
  output logic         zro_o,
  output logic         neg_o
);

  localparam int MSB = W - 1;

  alu_op_e      op;
  alu_cls_e     cls;
  logic [W-1:0] ar_sum;
  logic         ar_cry;
  logic         ar_ovf;
  logic [W-1:0] lg_res;
  logic [W-1:0] sh_res;
  logic         sh_cry;
  logic         sh_ovf;

  logic [W-1:0] res_n;
  logic [W-1:0] basis;
  alu_flags_t   flg_n;
  logic [W:0]   par_chain;

  assign op  = alu_op_e'(opc_i);
  assign cls = op_class(op);

  alu_arith #(.W(W)) u_arith (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .op_i  (op),
    .sum_o (ar_sum),
    .cry_o (ar_cry),
    .ovf_o (ar_ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .a_i   (opa_i),
    .b_i   (opb_i),
    .op_i  (op),
    .res_o (lg_res)
  );

  alu_shift #(.W(W)) u_shift (
    .a_i   (opa_i),
    .op_i  (op),
    .res_o (sh_res),
    .cry_o (sh_cry),
    .ovf_o (sh_ovf)
  );

  // Result steering and the value the flags are derived from.
  always_comb begin
    flg_n = '0;
    case (cls)
      CLS_ARITH: begin
        res_n     = (op == OP_CMP) ? opa_i : ar_sum;
        basis     = ar_sum;
        flg_n.cry = ar_cry;
        flg_n.ovf = ar_ovf;
      end
      CLS_SHIFT: begin
        res_n     = sh_res;
        basis     = sh_res;
        flg_n.cry = sh_cry;
        flg_n.ovf = sh_ovf;
      end
      default: begin
        res_n     = lg_res;
        basis     = lg_res;
      end
    endcase
    flg_n.par = par_chain[W];
    flg_n.zro = (basis == '0);
    flg_n.neg = basis[MSB];
    flg_n.pos = ~basis[MSB] & (basis != '0);
  end

  // Ripple parity chain over the basis bits.
  assign par_chain[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_par
    assign par_chain[i+1] = par_chain[i] ^ basis[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o <= '0;
      cry_o <= 1'b0;
      par_o <= 1'b0;
      ovf_o <= 1'b0;
      pos_o <= 1'b0;
      zro_o <= 1'b0;
      neg_o <= 1'b0;
    end else begin
      res_o <= res_n;
      cry_o <= flg_n.cry;
      par_o <= flg_n.par;
      ovf_o <= flg_n.ovf;
      pos_o <= flg_n.pos;
      zro_o <= flg_n.zro;
      neg_o <= flg_n.neg;
    end
  end

endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opa_i,
  input logic [W-1:0] opb_i,
  input logic [3:0]   opc_i,
  input logic [W-1:0] res_o,
  input logic         cry_o,
  input logic         par_o,
  input logic         ovf_o,
  input logic         pos_o,
  input logic         zro_o,
  input logic         neg_o
);

  localparam logic [W-1:0] MIN_NEG = {1'b1, {(W-1){1'b0}}};

  // R1: a reset edge leaves every output cleared
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (res_o == '0) && !cry_o && !par_o && !ovf_o && !pos_o && !zro_o && !neg_o);

  // R6: logic and pass codes never raise carry or overflow
  a_r6_logic_quiet: assert property (@(posedge clk) disable iff (rst)
    (opc_i inside {4'b0100, 4'b0101, 4'b0110, 4'b0111, 4'b1000, 4'b1111})
    |=> !cry_o && !ovf_o);

  // R6: pass A returns the operand unchanged
  a_r6_pass_a: assert property (@(posedge clk) disable iff (rst)
    (opc_i == 4'b0110) |=> (res_o == $past(opa_i)));

  // R9: compare leaves A on the result port
  a_r9_cmp_keeps_a: assert property (@(posedge clk) disable iff (rst)
    (opc_i == 4'b1110) |=> (res_o == $past(opa_i)));

  // R9: compare of equal operands reports zero
  a_r9_cmp_equal: assert property (@(posedge clk) disable iff (rst)
    (opc_i == 4'b1110 && opa_i == opb_i) |=> zro_o && !cry_o && !ovf_o);

  // R5: negating the most negative value returns it with overflow
  a_r5_neg_min: assert property (@(posedge clk) disable iff (rst)
    (opc_i == 4'b1101 && opa_i == MIN_NEG) |=> (res_o == MIN_NEG) && ovf_o);

  // R7: plain shifts never flag overflow
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (opc_i inside {4'b1001, 4'b1010, 4'b1011}) |=> !ovf_o);

  // R10: outside compare, parity tracks the registered result
  a_r10_parity: assert property (@(posedge clk) disable iff (rst)
    (opc_i != 4'b1110) |=> (par_o == ^res_o));

  // R11: sign classification is exclusive
  a_r11_sign_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pos_o, zro_o, neg_o}));

endmodule

bind flag_alu flag_alu_chk #(.W(W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .opa_i (opa_i),
  .opb_i (opb_i),
  .opc_i (opc_i),
  .res_o (res_o),
  .cry_o (cry_o),
  .par_o (par_o),
  .ovf_o (ovf_o),
  .pos_o (pos_o),
  .zro_o (zro_o),
  .neg_o (neg_o)
);

// File: tb/sim_flag_alu.sv
`timescale 1ns/1ps
module sim_flag_alu;

  localparam int W = 8;
  localparam int WD_NS = 400000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic [3:0]   opc = '0;
  logic [W-1:0] res;
  logic         cry, par, ovf, pos, zro, neg;

  int nchk = 0;
  int nbad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flag_alu #(.W(W)) u0 (
    .clk(clk), .rst(rst), .opa_i(opa), .opb_i(opb), .opc_i(opc),
    .res_o(res), .cry_o(cry), .par_o(par), .ovf_o(ovf),
    .pos_o(pos), .zro_o(zro), .neg_o(neg)
  );

  // packing: {result, carry, parity, overflow, positive, zero, negative}
  function automatic logic [13:0] pk(logic [7:0] r, logic c, logic p, logic v,
                                     logic ps, logic z, logic n);
    return {r, c, p, v, ps, z, n};
  endfunction

  function automatic logic [13:0] model(logic [3:0] op, logic [7:0] a, logic [7:0] b);
    int ua, ub, sa, sb, t;
    logic [7:0] r, bas;
    logic c, v;
    ua = int'(a); ub = int'(b);
    sa = int'($signed(a)); sb = int'($signed(b));
    c = 0; v = 0; r = a;
    case (op)
      4'b0000: begin t = ua + ub; r = t[7:0]; c = t > 255; t = sa + sb; v = t > 127 || t < -128; end
      4'b0001, 4'b1110: begin t = ua - ub; r = t[7:0]; c = ua < ub; t = sa - sb; v = t > 127 || t < -128; end
      4'b0010: begin t = ua + 1; r = t[7:0]; c = ua == 255; v = sa == 127; end
      4'b0011: begin t = ua - 1; r = t[7:0]; c = ua == 0; v = sa == -128; end
      4'b1101: begin t = 0 - ua; r = t[7:0]; c = ua != 0; v = sa == -128; end
      4'b0100: r = a & b;
      4'b0101: r = a | b;
      4'b0110: r = a;
      4'b0111: r = a ^ b;
      4'b1000: r = ~a;
      4'b1111: r = b;
      4'b1001: begin t = ua * 2; r = t[7:0]; c = a[7]; end
      4'b1010: begin t = ua / 2; r = t[7:0]; c = a[0]; end
      4'b1011: begin t = sa >>> 1; r = t[7:0]; c = a[0]; end
      default: begin t = ua * 2; r = t[7:0]; c = a[7]; v = a[7] != a[6]; end
    endcase
    bas = r;
    if (op == 4'b1110) r = a;
    return pk(r, c, ^bas, v, !bas[7] && bas != 0, bas == 0, bas[7]);
  endfunction

  function automatic string tag(logic [3:0] op);
    case (op)
      4'b0000: return "R2";
      4'b0001: return "R3";
      4'b0010, 4'b0011: return "R4";
      4'b1101: return "R5";
      4'b1001, 4'b1010, 4'b1011: return "R7";
      4'b1100: return "R8";
      4'b1110: return "R9";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [13:0] seen();
    return {res, cry, par, ovf, pos, zro, neg};
  endfunction

  task automatic compare(string req, logic [13:0] got, logic [13:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s: got res=%h flags(c,p,v,pos,z,n)=%b expected res=%h flags=%b",
               req, got[13:6], got[5:0], exp[13:6], exp[5:0]);
    end
  endtask

  // Drive away from the edge, sample one cycle later (R1 latency).
  task automatic apply(logic [3:0] op, logic [7:0] a, logic [7:0] b);
    @(negedge clk);
    opc = op; opa = a; opb = b;
    @(posedge clk);
    #1;
  endtask

  task automatic run_model(logic [3:0] op, logic [7:0] a, logic [7:0] b);
    apply(op, a, b);
    compare(tag(op), seen(), model(op, a, b));
  endtask

  task automatic run_fixed(string req, logic [3:0] op, logic [7:0] a, logic [7:0] b,
                           logic [13:0] exp);
    apply(op, a, b);
    compare(req, seen(), exp);
    compare(req, seen(), model(op, a, b));
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1; opc = 4'b0000; opa = 8'h7F; opb = 8'h01;
    @(posedge clk); #1;
    compare("R1 reset", seen(), 14'd0);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    compare("R1 latency", seen(), pk(8'h80, 0, 1, 1, 0, 0, 1));
  endtask

  task automatic t_add();
    run_fixed("R2 wrap", 4'b0000, 8'hFF, 8'h01, pk(8'h00, 1, 0, 0, 0, 1, 0));
    run_fixed("R2 sovf", 4'b0000, 8'h7F, 8'h01, pk(8'h80, 0, 1, 1, 0, 0, 1));
    run_fixed("R2 negovf", 4'b0000, 8'h80, 8'h80, pk(8'h00, 1, 0, 1, 0, 1, 0));
  endtask

  task automatic t_sub();
    run_fixed("R3 borrow", 4'b0001, 8'h05, 8'h07, pk(8'hFE, 1, 1, 0, 0, 0, 1));
    run_fixed("R3 sovf", 4'b0001, 8'h80, 8'h01, pk(8'h7F, 0, 1, 1, 1, 0, 0));
  endtask

  task automatic t_step();
    run_fixed("R4 inc FF", 4'b0010, 8'hFF, 8'h00, pk(8'h00, 1, 0, 0, 0, 1, 0));
    run_fixed("R4 inc 7F", 4'b0010, 8'h7F, 8'h00, pk(8'h80, 0, 1, 1, 0, 0, 1));
    run_fixed("R4 dec 00", 4'b0011, 8'h00, 8'h00, pk(8'hFF, 1, 0, 0, 0, 0, 1));
    run_fixed("R4 dec 80", 4'b0011, 8'h80, 8'h00, pk(8'h7F, 0, 1, 1, 1, 0, 0));
    for (int i = 0; i < 256; i++) run_model(4'b0010, 8'(i), 8'(i * 3));
    for (int i = 0; i < 256; i++) run_model(4'b0011, 8'(i), 8'(i * 5));
  endtask

  task automatic t_neg();
    run_fixed("R5 min", 4'b1101, 8'h80, 8'h00, pk(8'h80, 1, 1, 1, 0, 0, 1));
    run_fixed("R5 zero", 4'b1101, 8'h00, 8'h00, pk(8'h00, 0, 0, 0, 0, 1, 0));
    run_fixed("R5 one", 4'b1101, 8'h01, 8'h00, pk(8'hFF, 1, 0, 0, 0, 0, 1));
    for (int i = 0; i < 256; i++) run_model(4'b1101, 8'(i), 8'hA5);
  endtask

  task automatic t_logic();
    run_fixed("R6 and", 4'b0100, 8'hF0, 8'h3C, pk(8'h30, 0, 0, 0, 1, 0, 0));
    run_fixed("R6 nota", 4'b1000, 8'h00, 8'h55, pk(8'hFF, 0, 0, 0, 0, 0, 1));
    run_fixed("R6 passb", 4'b1111, 8'hFF, 8'h5A, pk(8'h5A, 0, 0, 0, 1, 0, 0));
    run_fixed("R6 passa", 4'b0110, 8'h01, 8'hFF, pk(8'h01, 0, 1, 0, 1, 0, 0));
  endtask

  task automatic t_shift();
    run_fixed("R7 lsl", 4'b1001, 8'h81, 8'h00, pk(8'h02, 1, 1, 0, 1, 0, 0));
    run_fixed("R7 lsr", 4'b1010, 8'h81, 8'h00, pk(8'h40, 1, 1, 0, 1, 0, 0));
    run_fixed("R7 asr", 4'b1011, 8'h81, 8'h00, pk(8'hC0, 1, 0, 0, 0, 0, 1));
    run_fixed("R8 asl sign", 4'b1100, 8'h40, 8'h00, pk(8'h80, 0, 1, 1, 0, 0, 1));
    run_fixed("R8 asl keep", 4'b1100, 8'hC0, 8'h00, pk(8'h80, 1, 1, 0, 0, 0, 1));
  endtask

  task automatic t_cmp();
    run_fixed("R9 equal", 4'b1110, 8'h33, 8'h33, pk(8'h33, 0, 0, 0, 0, 1, 0));
    run_fixed("R9 sovf", 4'b1110, 8'h80, 8'h01, pk(8'h80, 0, 1, 1, 1, 0, 0));
    run_fixed("R9 less", 4'b1110, 8'h02, 8'h03, pk(8'h02, 1, 0, 0, 0, 0, 1));
  endtask

  // R10 R11: pseudo-random stream across all codes
  task automatic t_sweep();
    logic [15:0] s = 16'hACE1;
    for (int i = 0; i < 1024; i++) begin
      s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
      run_model(4'(i), s[7:0], s[15:8] ^ 8'(i));
    end
  endtask

  initial begin
    #(WD_NS);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_add();
    t_sub();
    t_step();
    t_neg();
    t_logic();
    t_shift();
    t_cmp();
    t_sweep();
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

endmodule